// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block looks at the destination address of each incoming Ethernet frame, one byte per cycle as the bytes arrive, and decides whether the frame is kept. It holds no frame data. A frame-start strobe arms it. The first six valid bytes after that strobe are taken as the destination address. All later bytes are ignored until the next strobe.

The decision combines several checks. One programmed station address is matched exactly. Multicast addresses are tested against a 64-bin hash table indexed by CRC-32 bits. The filter modes are promiscuous, pass-all-with-status, pass-all-multicast, inverse unicast matching and broadcast blocking. These are settled with a fixed priority.

The result appears one cycle after the sixth address byte. It consists of a one-cycle done pulse, an accept bit, the plain filter verdict and the classification flags. The registered results stay valid until the next done pulse.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_done`, `res_accept`, `res_filter_pass` and all four flags are 0.
- R2: Byte k (k = 0..5) of the address is the k-th valid byte after `frm_start`, and it is compared with `station_addr[8k+7:8k]`. `res_addr_hit` is 1 exactly when all six bytes are equal. With no mode bit set, a unicast frame is accepted exactly when `res_addr_hit` is 1.
- R3: `res_mcast` is bit 0 of byte 0. `res_bcast` is 1 only when all 48 address bits are 1.
- R4: The hash index is bits [31:26] of a CRC register built as follows. The register starts at all ones and uses the reflected polynomial 0xEDB88320. Each byte is fed LSB first, bytes in arrival order, and no final inversion is applied. `res_hash_hit` is `res_mcast` AND `hash_tbl[index]`. A non-broadcast multicast frame passes the filter when `res_hash_hit` or `cfg_all_mcast` is 1.
- R5: A broadcast frame passes the filter unless `cfg_no_bcast` is 1.
- R6: With `cfg_inverse` set, a unicast frame passes the filter exactly when `res_addr_hit` is 0.
- R7: `cfg_promisc` forces `res_accept` to 1. `res_filter_pass` still shows the verdict of R2 to R6.
- R8: `cfg_pass_all` forces `res_accept` to 1. `res_filter_pass` still shows the verdict of R2 to R6.
- R9: `res_done` is a one-cycle pulse in the cycle after the sixth address byte is taken. All result outputs hold their values until the next pulse.
- R10: Valid bytes that arrive after the sixth byte, or before any `frm_start`, change no output.
- R11: A `frm_start` during an address restarts collection. A valid byte in the strobe cycle counts as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Arms the filter for a new frame |
| byte_vld | input | 1 | `byte_dat` holds a received byte |
| byte_dat | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_tbl | input | 64 | Multicast hash bins |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_pass_all | input | 1 | Accept every frame, report verdict |
| cfg_all_mcast | input | 1 | Pass every multicast frame |
| cfg_inverse | input | 1 | Invert the unicast match |
| cfg_no_bcast | input | 1 | Block broadcast frames |
| res_done | output | 1 | Result strobe |
| res_accept | output | 1 | Frame is kept |
| res_filter_pass | output | 1 | Verdict before the promiscuous and pass-all overrides |
| res_bcast | output | 1 | Address is broadcast |
| res_mcast | output | 1 | Address is multicast |
| res_hash_hit | output | 1 | Multicast address hits a set bin |
| res_addr_hit | output | 1 | Address equals the station address |

## Verification
A fault in the byte counter or the arming flag shows up at the first affected frame. The done pulse then arrives early, late or twice, or stray bytes after the sixth one overwrite the held results. A fault in the CRC register or its seed moves the hash index to another bin. A table that sets only the expected bin then shows a hash miss on the same frame's result. The bench sweeps every mode combination over unicast, broadcast and multicast addresses, so a wrong priority between modes is visible in the accept and verdict bits of the first frame that exercises it.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

   typedef struct packed {
      logic accept;
      logic filt_pass;
      logic bcast;
      logic mcast;
      logic hash_hit;
      logic addr_hit;
   } verdict_t;
endpackage

// File: rtl/rxaf_byte_collect.sv
module rxaf_byte_collect #(
   parameter int ADDR_BYTES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frm_start,
   input  logic                    byte_vld,
   input  logic [7:0]              byte_dat,
   output logic                    take,
   output logic                    first,
   output logic                    last,
   output logic [8*ADDR_BYTES-1:0] addr_full
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 1);

   if (ADDR_BYTES < 2) begin : g_bad_bytes
      $error("rxaf_byte_collect: ADDR_BYTES must be at least 2");
   end

   logic [CNT_W-1:0]        cnt_q, cnt_eff;
   logic                    armed_q;
   logic [8*ADDR_BYTES-1:0] sr_q;

   assign cnt_eff = frm_start ? '0 : cnt_q;
   assign take    = byte_vld & (frm_start | armed_q);
   assign first   = take & (cnt_eff == '0);
   assign last    = take & (cnt_eff == CNT_W'(ADDR_BYTES - 1));

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_slot
      logic hit_k;
      assign hit_k = take & (cnt_eff == CNT_W'(k));
      assign addr_full[8*k +: 8] = hit_k ? byte_dat : sr_q[8*k +: 8];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     sr_q[8*k +: 8] <= '0;
         else if (hit_k) sr_q[8*k +: 8] <= byte_dat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (last) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            if (frm_start) armed_q <= 1'b1;
            if (take)      cnt_q   <= cnt_eff + 1'b1;
            else           cnt_q   <= cnt_eff;
         end
      end
   end

   // R10: no byte is taken while disarmed
   a_r10_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !frm_start) |-> !take);
   // R11: a frame start always lands on slot 0
   a_r11_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_start && byte_vld) |-> first);
endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
   parameter int HASH_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 first,
   input  logic [7:0]           byte_dat,
   output logic [HASH_BITS-1:0] idx
);
   import rxaf_pkg::*;

   if (HASH_BITS < 1 || HASH_BITS > 16) begin : g_bad_hash
      $error("rxaf_hash: HASH_BITS must lie in 1..16");
   end

   logic [31:0] crc_q;
   logic [31:0] stg [0:8];

   assign stg[0] = first ? CRC_SEED : crc_q;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb         = stg[b][0] ^ byte_dat[b];
      assign stg[b + 1] = fb ? ((stg[b] >> 1) ^ CRC_POLY_REFL) : (stg[b] >> 1);
   end

   assign idx = stg[8][31 -: HASH_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= CRC_SEED;
      else if (take) crc_q <= stg[8];
   end

   // R4: register only moves when a byte is taken
   a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(crc_q));
endmodule

// File: rtl/rxaf_verdict.sv
module rxaf_verdict #(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6
) (
   input  logic [8*ADDR_BYTES-1:0]   addr_full,
   input  logic [8*ADDR_BYTES-1:0]   station_addr,
   input  logic [HASH_BITS-1:0]      idx,
   input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
   input  logic                      cfg_promisc,
   input  logic                      cfg_pass_all,
   input  logic                      cfg_all_mcast,
   input  logic                      cfg_inverse,
   input  logic                      cfg_no_bcast,
   output rxaf_pkg::verdict_t        vd
);
   import rxaf_pkg::*;

   logic is_bcast, is_mcast, hh, ah, pass_v;

   assign is_mcast = addr_full[0];
   assign is_bcast = &addr_full;
   assign ah       = (addr_full == station_addr);
   assign hh       = is_mcast & hash_tbl[idx];

   always_comb begin
      if (is_bcast)      pass_v = ~cfg_no_bcast;
      else if (is_mcast) pass_v = cfg_all_mcast | hh;
      else if (cfg_inverse) pass_v = ~ah;
      else               pass_v = ah;
   end

   always_comb begin
      vd.bcast     = is_bcast;
      vd.mcast     = is_mcast;
      vd.hash_hit  = hh;
      vd.addr_hit  = ah;
      vd.filt_pass = pass_v;
      vd.accept    = cfg_promisc | cfg_pass_all | pass_v;
   end

   // R3: broadcast is always a multicast address
   a_r3_bcast_is_mcast: assert final (!is_bcast || is_mcast);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int ADDR_BYTES = 6,
   parameter int HASH_BITS  = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frm_start,
   input  logic                      byte_vld,
   input  logic [7:0]                byte_dat,
   input  logic [8*ADDR_BYTES-1:0]   station_addr,
   input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
   input  logic                      cfg_promisc,
   input  logic                      cfg_pass_all,
   input  logic                      cfg_all_mcast,
   input  logic                      cfg_inverse,
   input  logic                      cfg_no_bcast,
   output logic                      res_done,
   output logic                      res_accept,
   output logic                      res_filter_pass,
   output logic                      res_bcast,
   output logic                      res_mcast,
   output logic                      res_hash_hit,
   output logic                      res_addr_hit
);
   import rxaf_pkg::*;

   logic                    take, first, last;
   logic [8*ADDR_BYTES-1:0] addr_full;
   logic [HASH_BITS-1:0]    idx;
   verdict_t                vd, vd_q;
   logic                    done_q;

   rxaf_byte_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .take(take), .first(first), .last(last),
      .addr_full(addr_full));

   rxaf_hash #(.HASH_BITS(HASH_BITS)) u_hash (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first),
      .byte_dat(byte_dat), .idx(idx));

   rxaf_verdict #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_verdict (
      .addr_full(addr_full), .station_addr(station_addr), .idx(idx),
      .hash_tbl(hash_tbl), .cfg_promisc(cfg_promisc), .cfg_pass_all(cfg_pass_all),
      .cfg_all_mcast(cfg_all_mcast), .cfg_inverse(cfg_inverse),
      .cfg_no_bcast(cfg_no_bcast), .vd(vd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         vd_q   <= '0;
      end else begin
         done_q <= last;
         if (last) vd_q <= vd;
      end
   end

   assign res_done        = done_q;
   assign res_accept      = vd_q.accept;
   assign res_filter_pass = vd_q.filt_pass;
   assign res_bcast       = vd_q.bcast;
   assign res_mcast       = vd_q.mcast;
   assign res_hash_hit    = vd_q.hash_hit;
   assign res_addr_hit    = vd_q.addr_hit;

   // R9: done is a single-cycle pulse following the last byte
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);
   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> res_done);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> $stable(res_accept) && $stable(res_filter_pass));
   // R7 / R8: overrides force acceptance
   a_r7_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (last && (cfg_promisc || cfg_pass_all)) |=> res_accept);
   // R4: a hash hit needs a multicast address
   a_r4_hit_mcast: assert property (@(posedge clk) disable iff (!rst_n)
      res_hash_hit |-> res_mcast);
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_start = 1'b0, byte_vld = 1'b0;
   logic [7:0]  byte_dat = '0;
   logic [47:0] station_addr = 48'h6E5D4C331A02;
   logic [63:0] hash_tbl = '0;
   logic        cfg_promisc = 0, cfg_pass_all = 0, cfg_all_mcast = 0,
                cfg_inverse = 0, cfg_no_bcast = 0;
   logic        res_done, res_accept, res_filter_pass, res_bcast, res_mcast,
                res_hash_hit, res_addr_hit;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .station_addr(station_addr), .hash_tbl(hash_tbl),
      .cfg_promisc(cfg_promisc), .cfg_pass_all(cfg_pass_all),
      .cfg_all_mcast(cfg_all_mcast), .cfg_inverse(cfg_inverse),
      .cfg_no_bcast(cfg_no_bcast), .res_done(res_done), .res_accept(res_accept),
      .res_filter_pass(res_filter_pass), .res_bcast(res_bcast),
      .res_mcast(res_mcast), .res_hash_hit(res_hash_hit),
      .res_addr_hit(res_addr_hit));

   task automatic check(input bit ok, input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFFFFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[0] ^ a[i];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c[31:26];
   endfunction

   // {accept, filter_pass, bcast, mcast, hash_hit, addr_hit}
   function automatic logic [5:0] model(input logic [47:0] a, input logic [4:0] m);
      logic bc = (a == 48'hFFFFFFFFFFFF);
      logic mc = a[0];
      logic ah = (a == station_addr);
      logic hh = mc & hash_tbl[hidx(a)];
      logic fp;
      if (bc)      fp = !m[4];
      else if (mc) fp = m[2] | hh;
      else if (m[3]) fp = !ah;
      else         fp = ah;
      return {m[0] | m[1] | fp, fp, bc, mc, hh, ah};
   endfunction

   function automatic logic [5:0] outs();
      return {res_accept, res_filter_pass, res_bcast, res_mcast, res_hash_hit, res_addr_hit};
   endfunction

   task automatic send(input logic [47:0] a, input bit strobe);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         frm_start = strobe && (k == 0);
         byte_vld  = 1'b1;
         byte_dat  = a[8*k +: 8];
      end
      @(negedge clk);
      frm_start = 1'b0;
      byte_vld  = 1'b0;
   endtask

   function automatic string tag_of(input logic [47:0] a, input logic [4:0] m);
      if (m[0]) return "R7";
      if (m[1]) return "R8";
      if (a == 48'hFFFFFFFFFFFF) return "R5";
      if (a[0]) return "R4";
      if (m[3]) return "R6";
      return "R2";
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] addrs [0:5];
      logic [5:0]  exp, held;
      addrs[0] = station_addr;
      addrs[1] = station_addr ^ 48'h010000000000;
      addrs[2] = 48'hFFFFFFFFFFFF;
      addrs[3] = 48'hFB00005E0001;
      addrs[4] = 48'hFB00005E0001;
      addrs[5] = 48'h010000003333;

      #1;
      check(outs() == 0 && res_done == 0, "R1 reset", {1'b0, res_done, outs()}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(outs() == 0 && res_done == 0, "R1 after release", {1'b0, res_done, outs()}, 0);

      // R10: bytes before any frame start
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); byte_vld = 1; byte_dat = 8'hFF;
      end
      @(negedge clk); byte_vld = 0;
      repeat (2) @(negedge clk);
      check(res_done == 0 && outs() == 0, "R10 unarmed bytes", {1'b0, res_done, outs()}, 0);

      for (int m = 0; m < 32; m++) begin
         for (int j = 0; j < 6; j++) begin
            logic [5:0] hi = hidx(addrs[j]);
            {cfg_no_bcast, cfg_inverse, cfg_all_mcast, cfg_pass_all, cfg_promisc} = 5'(m);
            if (j == 3)      hash_tbl = 64'd1 << hi;
            else if (j == 4) hash_tbl = ~(64'd1 << hi);
            else             hash_tbl = 64'h5A5A_C3C3_0F0F_9669;
            exp = model(addrs[j], 5'(m));
            send(addrs[j], 1'b1);
            check(res_done == 1'b1, "R9 done strobe", {7'b0, res_done}, 8'd1);
            check(outs() == exp, tag_of(addrs[j], 5'(m)), {2'b0, outs()}, {2'b0, exp});
            check(outs()[3:2] == exp[3:2], "R3 flags", {6'b0, outs()[3:2]}, {6'b0, exp[3:2]});
            held = outs();
            @(negedge clk);
            check(res_done == 0 && outs() == held, "R9 pulse and hold",
                  {1'b0, res_done, outs()}, {2'b0, held});
         end
      end

      // R10: trailing bytes after the sixth change nothing
      {cfg_no_bcast, cfg_inverse, cfg_all_mcast, cfg_pass_all, cfg_promisc} = 5'b0;
      send(station_addr, 1'b1);
      held = outs();
      send(48'hFFFFFFFFFFFF, 1'b0);
      @(negedge clk);
      check(res_done == 0 && outs() == held, "R10 trailing bytes",
            {1'b0, res_done, outs()}, {2'b0, held});

      // R11: restart in the middle of an address
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); frm_start = (k == 0); byte_vld = 1; byte_dat = 8'hFF;
      end
      exp = model(station_addr, 5'b0);
      send(station_addr, 1'b1);
      check(res_done == 1 && outs() == exp, "R11 restart",
            {1'b0, res_done, outs()}, {2'b1, exp});

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule